// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Flag Timing

This block carries 36-bit words from a write clock domain to a read clock domain. The two free-running clocks may be unrelated or may be one and the same net. The buffer holds 2^DEPTH_LOG2 words, where DEPTH_LOG2 is 8, 9 or 10. Each side keeps its own binary pointer. The pointer crosses to the other side as Gray code through a two-flop synchronizer, so every flag is a registered output of the clock that owns it.

A static mode input sets how the flags behave. In standard mode the read side shows an empty flag, the write side shows a full flag, and a word reaches the output only after a read request. In fall-through mode the read side shows output-ready and the write side shows input-ready. The head word is moved into the output register without any request, so the output register acts as one extra storage slot.

Almost-empty and almost-full compare the fill level with offsets. The offsets are captured from a two-bit select input while reset is held: three fixed values, or two values supplied on dedicated inputs.

Top module: `dcf_top`

## Requirements
- R1: Words leave in the order written, with all 36 bits intact. Depth is 2^DEPTH_LOG2 with DEPTH_LOG2 in {8, 9, 10}.
- R2: Standard mode: a read request while the empty flag (`rflag`) is 0 loads the next word into `dout` on that read edge. Without such a request `dout` holds its value.
- R3: A write request while the memory holds DEPTH words is ignored. The write pointer does not move and the word is never read out. In standard mode `wflag` is the full flag and becomes 1 after DEPTH accepted writes.
- R4: A read request when no word is available is ignored. The read pointer and `dout` stay unchanged. In standard mode `rflag` stays 1; in fall-through mode it stays 0.
- R5: Fall-through mode: after the first write, the first word appears on `dout` with `rflag` (output-ready) at 1, with no read request. A read request while `rflag`=1 takes that word. `rflag` drops on the same read edge that takes the last word.
- R6: Fall-through mode: `wflag` is input-ready. Once the crossing has settled, the block accepts DEPTH+1 words (DEPTH in memory plus one in the output register), after which `wflag` is 0.
- R7: `aempty` is 1 exactly when the stored word count is at most the almost-empty offset. The count includes the output-register word in fall-through mode. `aempty` is updated on the read clock.
- R8: `afull` is 1 exactly when DEPTH minus the words held in memory is at most the almost-full offset. `afull` is updated on the write clock.
- R9: `fs_sel` is sampled while `rst_n`=0. Value 0 selects offsets of 8, value 1 selects 16, value 2 selects 64, and value 3 takes `ae_prog`/`af_prog`.
- R10: After reset the memory is empty: `aempty`=1, `afull`=0 and `dout`=0. Standard mode gives `wflag`=0 and `rflag`=1; fall-through mode gives `wflag`=1 and `rflag`=0.
- R11: A write and a read on the same edge of a shared clock both complete, and the stream stays in order.
- R12: The Gray pointer sent across the clock boundary changes in at most one bit per source clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; clocks run while it is low |
| fwft_mode | input | 1 | 1 = fall-through flags, 0 = standard flags; held static |
| fs_sel | input | 2 | Offset select, sampled during reset |
| ae_prog | input | DEPTH_LOG2 | User almost-empty offset (fs_sel = 3) |
| af_prog | input | DEPTH_LOG2 | User almost-full offset (fs_sel = 3) |
| wr_en | input | 1 | Write request |
| din | input | 36 | Write data |
| wflag | output | 1 | Full (standard) or input-ready (fall-through) |
| afull | output | 1 | Almost-full flag |
| rd_en | input | 1 | Read request |
| dout | output | 36 | Read data register |
| rflag | output | 1 | Empty (standard) or output-ready (fall-through) |
| aempty | output | 1 | Almost-empty flag |

## Verification
A write and a read can fall on the same clock edge. The bench drives both ports from one 125 MHz clock to force this. It primes four words and then asserts `wr_en` and `rd_en` together for forty edges, checking each read word against a counter-derived pattern. It then drains the remainder to confirm that no write was lost. Sweeps that fill and drain the buffer word by word, in both modes and for all four offset selections, compare every flag with values computed from the word count.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;
    localparam int DATA_W = 36;

    typedef enum logic [1:0] {
        OFS_SMALL  = 2'd0,
        OFS_MID    = 2'd1,
        OFS_LARGE  = 2'd2,
        OFS_USER   = 2'd3
    } ofs_sel_e;

    localparam int OFS_SMALL_V = 8;
    localparam int OFS_MID_V   = 16;
    localparam int OFS_LARGE_V = 64;
endpackage

// File: rtl/dcf_sync.sv
`timescale 1ns/1ps
module dcf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q, s2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
    parameter int AW = 8,
    parameter int DW = 36
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fwft,
    input  logic [1:0]    fs_sel,
    input  logic [AW-1:0] af_prog,
    input  logic          wr_en,
    input  logic [AW:0]   rgray_s,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          afull,
    output logic          wflag
);
    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] ONE_V   = (AW+1)'(1);

    typedef struct packed {
        logic [AW:0] ptr;
        logic [AW:0] gray;
        logic        full;
        logic        afull;
    } wst_t;

    wst_t          st_d, st_q;
    logic [AW-1:0] ofs_d, ofs_q;
    logic [AW:0]   rbin, used, free;
    logic          accept;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        case (ofs_sel_e'(fs_sel))
            OFS_SMALL: ofs_d = AW'(OFS_SMALL_V);
            OFS_MID:   ofs_d = AW'(OFS_MID_V);
            OFS_LARGE: ofs_d = AW'(OFS_LARGE_V);
            default:   ofs_d = af_prog;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= ofs_d;
    end

    always_comb begin
        st_d     = st_q;
        rbin     = g2b(rgray_s);
        accept   = wr_en && !st_q.full;
        if (accept) st_d.ptr = st_q.ptr + ONE_V;
        st_d.gray  = st_d.ptr ^ (st_d.ptr >> 1);
        used       = st_d.ptr - rbin;
        free       = DEPTH_V - used;
        st_d.full  = (used == DEPTH_V);
        st_d.afull = (free <= {1'b0, ofs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, gray: '0, full: 1'b0, afull: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign we    = accept;
    assign waddr = st_q.ptr[AW-1:0];
    assign wptr  = st_q.ptr;
    assign wgray = st_q.gray;
    assign full  = st_q.full;
    assign afull = st_q.afull;
    assign wflag = fwft ? !st_q.full : st_q.full;
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwft,
    input  logic [1:0]        fs_sel,
    input  logic [AW-1:0]     ae_prog,
    input  logic              rd_en,
    input  logic [AW:0]       wgray_s,
    input  logic [DATA_W-1:0] rdata,
    output logic [AW-1:0]     raddr,
    output logic [AW:0]       rptr,
    output logic [AW:0]       rgray,
    output logic [AW:0]       avail,
    output logic [DATA_W-1:0] dout,
    output logic              rflag,
    output logic              aempty
);
    localparam logic [AW:0] ONE_V = (AW+1)'(1);

    typedef struct packed {
        logic [AW:0]        ptr;
        logic [AW:0]        gray;
        logic               empty;
        logic               ovalid;
        logic [DATA_W-1:0]  dout;
        logic               aempty;
    } rst_t;

    rst_t          st_d, st_q;
    logic [AW-1:0] ofs_d, ofs_q;
    logic [AW:0]   wbin, left;
    logic [AW+1:0] held;
    logic          take, load;

    function automatic logic [AW:0] g2b(input logic [AW:0] g);
        logic [AW:0] b;
        b[AW] = g[AW];
        for (int i = AW - 1; i >= 0; i--) b[i] = b[i+1] ^ g[i];
        return b;
    endfunction

    always_comb begin
        case (ofs_sel_e'(fs_sel))
            OFS_SMALL: ofs_d = AW'(OFS_SMALL_V);
            OFS_MID:   ofs_d = AW'(OFS_MID_V);
            OFS_LARGE: ofs_d = AW'(OFS_LARGE_V);
            default:   ofs_d = ae_prog;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ofs_q <= ofs_d;
    end

    always_comb begin
        st_d  = st_q;
        wbin  = g2b(wgray_s);
        avail = wbin - st_q.ptr;
        take  = 1'b0;
        if (fwft) begin
            take = rd_en && st_q.ovalid;
            load = (avail != '0) && (!st_q.ovalid || take);
        end else begin
            load = rd_en && !st_q.empty;
        end
        if (load) begin
            st_d.ptr  = st_q.ptr + ONE_V;
            st_d.dout = rdata;
        end
        if (fwft) begin
            if (load)      st_d.ovalid = 1'b1;
            else if (take) st_d.ovalid = 1'b0;
        end
        st_d.gray   = st_d.ptr ^ (st_d.ptr >> 1);
        left        = wbin - st_d.ptr;
        st_d.empty  = (left == '0);
        held        = {1'b0, left} + {{(AW+1){1'b0}}, fwft && st_d.ovalid};
        st_d.aempty = (held <= {2'b00, ofs_q});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, gray: '0, empty: 1'b1, ovalid: 1'b0,
                      dout: '0, aempty: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr  = st_q.ptr[AW-1:0];
    assign rptr   = st_q.ptr;
    assign rgray  = st_q.gray;
    assign dout   = st_q.dout;
    assign aempty = st_q.aempty;
    assign rflag  = fwft ? st_q.ovalid : st_q.empty;
endmodule

// File: rtl/dcf_top.sv
`timescale 1ns/1ps
module dcf_top
    import dcf_pkg::*;
#(
    parameter int DEPTH_LOG2 = 8
) (
    input  logic                  wclk,
    input  logic                  rclk,
    input  logic                  rst_n,
    input  logic                  fwft_mode,
    input  logic [1:0]            fs_sel,
    input  logic [DEPTH_LOG2-1:0] ae_prog,
    input  logic [DEPTH_LOG2-1:0] af_prog,
    input  logic                  wr_en,
    input  logic [DATA_W-1:0]     din,
    output logic                  wflag,
    output logic                  afull,
    input  logic                  rd_en,
    output logic [DATA_W-1:0]     dout,
    output logic                  rflag,
    output logic                  aempty
);
    localparam int AW = DEPTH_LOG2;

    logic              we, full_w;
    logic [AW-1:0]     waddr, raddr;
    logic [AW:0]       wptr, rptr, wgray, rgray, wgray_s, rgray_s, avail;
    logic [DATA_W-1:0] rdata;

    dcf_ram #(.AW(AW), .DW(DATA_W)) u_ram (
        .wclk (wclk), .we (we), .waddr (waddr), .wdata (din),
        .raddr (raddr), .rdata (rdata)
    );

    dcf_sync #(.W(AW+1)) u_sync_w2r (
        .clk (rclk), .rst_n (rst_n), .d (wgray), .q (wgray_s)
    );

    dcf_sync #(.W(AW+1)) u_sync_r2w (
        .clk (wclk), .rst_n (rst_n), .d (rgray), .q (rgray_s)
    );

    dcf_wr_side #(.AW(AW)) u_wr (
        .clk (wclk), .rst_n (rst_n), .fwft (fwft_mode), .fs_sel (fs_sel),
        .af_prog (af_prog), .wr_en (wr_en), .rgray_s (rgray_s),
        .we (we), .waddr (waddr), .wptr (wptr), .wgray (wgray),
        .full (full_w), .afull (afull), .wflag (wflag)
    );

    dcf_rd_side #(.AW(AW)) u_rd (
        .clk (rclk), .rst_n (rst_n), .fwft (fwft_mode), .fs_sel (fs_sel),
        .ae_prog (ae_prog), .rd_en (rd_en), .wgray_s (wgray_s),
        .rdata (rdata), .raddr (raddr), .rptr (rptr), .rgray (rgray),
        .avail (avail), .dout (dout), .rflag (rflag), .aempty (aempty)
    );

    initial begin
        if (DEPTH_LOG2 < 8 || DEPTH_LOG2 > 10)
            $error("DEPTH_LOG2 must be 8, 9 or 10");
    end
endmodule

// File: rtl/dcf_checker.sv
`timescale 1ns/1ps
module dcf_checker #(
    parameter int AW = 8
) (
    input logic        wclk,
    input logic        rclk,
    input logic        rst_n,
    input logic        fwft_mode,
    input logic        wr_en,
    input logic        rd_en,
    input logic        full_w,
    input logic        rflag,
    input logic [35:0] dout,
    input logic [AW:0] wptr,
    input logic [AW:0] rptr,
    input logic [AW:0] wgray,
    input logic [AW:0] rgray,
    input logic [AW:0] avail
);
    // R3: a write while full must leave the write pointer in place
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (!rst_n)
        (wr_en && full_w) |=> $stable(wptr));

    // R4: with nothing available the read pointer cannot move
    p_no_underflow_r4: assert property (@(posedge rclk) disable iff (!rst_n)
        (avail == '0) |=> $stable(rptr));

    // R2: standard mode output only moves on an accepted read
    p_std_dout_hold_r2: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fwft_mode && !(rd_en && !rflag)) |=> $stable(dout));

    // R5: a presented head word stays until it is taken
    p_fwft_head_hold_r5: assert property (@(posedge rclk) disable iff (!rst_n)
        (fwft_mode && rflag && !rd_en) |=> (rflag && $stable(dout)));

    // R12: Gray pointers toggle at most one bit per edge
    p_wgray_step_r12: assert property (@(posedge wclk) disable iff (!rst_n)
        $onehot0(wgray ^ $past(wgray)));

    p_rgray_step_r12: assert property (@(posedge rclk) disable iff (!rst_n)
        $onehot0(rgray ^ $past(rgray)));
endmodule

bind dcf_top dcf_checker #(.AW(DEPTH_LOG2)) u_chk (
    .wclk (wclk), .rclk (rclk), .rst_n (rst_n), .fwft_mode (fwft_mode),
    .wr_en (wr_en), .rd_en (rd_en), .full_w (full_w), .rflag (rflag),
    .dout (dout), .wptr (wptr), .rptr (rptr), .wgray (wgray),
    .rgray (rgray), .avail (avail)
);

// File: tb/dcf_top_tb_top.sv
`timescale 1ns/1ps
module dcf_top_tb_top;
    localparam int AW    = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft_mode = 1'b0;
    logic [1:0]    fs_sel = 2'd0;
    logic [AW-1:0] ae_prog = '0;
    logic [AW-1:0] af_prog = '0;
    logic          wr_en = 1'b0;
    logic [35:0]   din = '0;
    logic          rd_en = 1'b0;
    logic          wflag, afull, rflag, aempty;
    logic [35:0]   dout;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    dcf_top #(.DEPTH_LOG2(AW)) dut_i (
        .wclk (clk), .rclk (clk), .rst_n (rst_n), .fwft_mode (fwft_mode),
        .fs_sel (fs_sel), .ae_prog (ae_prog), .af_prog (af_prog),
        .wr_en (wr_en), .din (din), .wflag (wflag), .afull (afull),
        .rd_en (rd_en), .dout (dout), .rflag (rflag), .aempty (aempty)
    );

    function automatic logic [35:0] pat(input int k);
        return {4'h5, k[15:0], ~k[15:0]};
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (8) @(negedge clk);
    endtask

    task automatic do_reset(input logic m, input logic [1:0] fs,
                            input int aep, input int afp);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        fwft_mode = m; fs_sel = fs; ae_prog = AW'(aep); af_prog = AW'(afp);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: state right after reset
        chk("R10 wflag", 36'(wflag), 36'(m));
        chk("R10 rflag", 36'(rflag), 36'(!m));
        chk("R10 aempty", 36'(aempty), 36'd1);
        chk("R10 afull", 36'(afull), 36'd0);
        chk("R10 dout", dout, 36'd0);
    endtask

    task automatic wr1(input logic [35:0] d);
        wr_en = 1'b1; din = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd1();
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Flags computed from the total stored count n
    task automatic chk_flags(input logic m, input int n, input int aeo, input int afo);
        int core;
        core = m ? ((n > 0) ? n - 1 : 0) : n;
        chk("R7 aempty", 36'(aempty), 36'(n <= aeo));
        chk("R8 afull", 36'(afull), 36'((DEPTH - core) <= afo));
        if (m) begin
            chk("R6 input-ready", 36'(wflag), 36'(core < DEPTH));
            chk("R5 output-ready", 36'(rflag), 36'(n > 0));
        end else begin
            chk("R3 full", 36'(wflag), 36'(core == DEPTH));
            chk("R4 empty", 36'(rflag), 36'(n == 0));
        end
    endtask

    task automatic sweep(input logic m, input logic [1:0] fs,
                         input int aeo, input int afo, input int aep, input int afp);
        int total;
        do_reset(m, fs, aep, afp);
        // R4: read while empty changes nothing
        rd1();
        settle();
        chk("R4 dout after empty read", dout, 36'd0);
        chk_flags(m, 0, aeo, afo);
        total = m ? DEPTH + 1 : DEPTH;
        for (int n = 1; n <= total; n++) begin
            wr1(pat(n));
            settle();
            chk_flags(m, n, aeo, afo);
            if (m) chk("R5 head word", dout, pat(1));
        end
        // R3 / R6: extra writes when no room are dropped
        wr1(pat(9000));
        wr1(pat(9001));
        settle();
        chk_flags(m, total, aeo, afo);
        for (int k = 1; k <= total; k++) begin
            if (m) begin
                chk("R5 head before take", dout, pat(k));
                rd1();
                if (k == total) chk("R5 ready drops on last take", 36'(rflag), 36'd0);
                else            chk("R5 next head", dout, pat(k + 1));
            end else begin
                rd1();
                chk("R2 read data", dout, pat(k));
                if (k == total) chk("R2 empty on last read", 36'(rflag), 36'd1);
            end
            settle();
            chk_flags(m, total - k, aeo, afo);
        end
        // R4: read past the end leaves output and flags
        rd1();
        settle();
        chk("R4 dout held", dout, pat(total));
        chk_flags(m, 0, aeo, afo);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R10 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 R2 R3 R7 R8 R9: standard mode, small offsets
        sweep(1'b0, 2'd0, 8, 8, 0, 0);
        // R9: user offsets in standard mode
        sweep(1'b0, 2'd3, 5, 3, 5, 3);
        // R5 R6 R9: fall-through with middle and large offsets
        sweep(1'b1, 2'd1, 16, 16, 0, 0);
        sweep(1'b1, 2'd2, 64, 64, 0, 0);

        // R11: simultaneous write and read on a shared edge
        do_reset(1'b0, 2'd0, 0, 0);
        for (int i = 1; i <= 4; i++) wr1(pat(i));
        settle();
        for (int i = 0; i < 40; i++) begin
            wr_en = 1'b1; din = pat(5 + i); rd_en = 1'b1;
            @(negedge clk);
            chk("R11 same-edge read data", dout, pat(1 + i));
        end
        wr_en = 1'b0; rd_en = 1'b0;
        settle();
        chk_flags(1'b0, 4, 8, 8);
        for (int k = 41; k <= 44; k++) begin
            rd1();
            chk("R11 R1 remaining order", dout, pat(k));
        end
        settle();
        chk("R11 empty at end", 36'(rflag), 36'd1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule